// File: doc/BRIEF.md
# Branch and Loop Condition Resolver

This block decides whether a control-transfer instruction redirects the program and which instruction address comes next. Each cycle with a valid request it takes a 4-bit condition selector, four arithmetic flags, the current value of the loop-counter register, the fall-through address and the branch target. Exactly one cycle later it presents a registered result: the taken decision, the next instruction pointer, the counter value to write back and a write enable for that counter.

The condition set covers an unconditional jump, equality tests on the zero flag, signed orderings that compare the sign flag against the overflow flag, unsigned orderings built from carry and zero, and the two overflow tests. Three counted-loop forms decrement the counter. They redirect only while the decremented counter is non-zero, and two of them also require a given state of the zero flag. The flags are only read, never produced, so the flag state the block sees after a loop is the state that was fed to it.

Top module: `branch_resolver`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are `out_valid`=0, `taken`=0, `next_ip`=0, `ctr_out`=0 and `ctr_we`=0.
- R2: Each rising edge with `in_valid`=1 gives `out_valid`=1 after that edge with the result for that request. An edge with `in_valid`=0 gives `out_valid`=0.
- R3: Selector 0 (unconditional jump) is always taken and `next_ip` equals `tgt_ip`.
- R4: Selector 1 (equal) is taken when ZF=1 and selector 2 (not equal) when ZF=0. Flags bit positions: bit0 CF, bit1 ZF, bit2 SF, bit3 OF.
- R5: Signed conditions: selector 3 (greater) needs ZF=0 and SF=OF; 4 (greater-or-equal) needs SF=OF; 5 (less) needs SF≠OF; 6 (less-or-equal) needs SF≠OF or ZF=1.
- R6: Unsigned conditions: selector 7 (above) needs CF=0 and ZF=0; 8 (above-or-equal) needs CF=0; 9 (below) needs CF=1; 10 (below-or-equal) needs CF=1 or ZF=1.
- R7: Selector 11 is taken when OF=1 and selector 12 when OF=0.
- R8: A request that is taken gives `next_ip` = `tgt_ip`. A request that is not taken gives `next_ip` = `fall_ip`.
- R9: Selector 13 (plain loop) gives `ctr_out` = `ctr_in`-1 and is taken exactly when that decremented value is non-zero. The flags have no effect on it.
- R10: Selector 14 (loop while zero) is taken when the decremented counter is non-zero and ZF=1. Selector 15 (loop while not zero) is taken when the decremented counter is non-zero and ZF=0. A decremented value of zero forces fall-through in both.
- R11: Loop selectors (13–15) always give `ctr_we`=1, taken or not. Selectors 0–12 give `ctr_we`=0 and `ctr_out` = `ctr_in`.
- R12: The decrement wraps modulo 2^CTR_W, so `ctr_in`=0 on a loop gives an all-ones `ctr_out`, and the loop is taken if its flag condition holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| cond | input | 4 | Condition selector (0–15) |
| flags | input | 4 | {OF, SF, ZF, CF} |
| ctr_in | input | CTR_W | Current loop-counter value |
| fall_ip | input | ADDR_W | Address of the following instruction |
| tgt_ip | input | ADDR_W | Branch target address |
| out_valid | output | 1 | Result present |
| taken | output | 1 | Control transfer taken |
| next_ip | output | ADDR_W | Next instruction address |
| ctr_out | output | CTR_W | Counter value to write back |
| ctr_we | output | 1 | Counter write enable |

## Verification
The bench drives all sixteen flag combinations through every jump selector. This catches a swapped SF/OF comparison or a signed ordering that forgets ZF, either of which would redirect on equal operands or miss a taken case. Loop selectors are run with counters of 0, 1, 2, the sign boundary and all ones, against both ZF values. A design that tested the counter before decrementing would take the loop at a count of 1. A design that saturated instead of wrapping would fall through at 0. A design that gated the write enable on taken would leave the counter stale on the final pass.

// File: rtl/br_pkg.sv
package br_pkg;

  typedef enum logic [3:0] {
    BR_JMP    = 4'd0,
    BR_EQ     = 4'd1,
    BR_NE     = 4'd2,
    BR_SGT    = 4'd3,
    BR_SGE    = 4'd4,
    BR_SLT    = 4'd5,
    BR_SLE    = 4'd6,
    BR_UGT    = 4'd7,
    BR_UGE    = 4'd8,
    BR_ULT    = 4'd9,
    BR_ULE    = 4'd10,
    BR_OV     = 4'd11,
    BR_NOV    = 4'd12,
    BR_LOOP   = 4'd13,
    BR_LOOPZ  = 4'd14,
    BR_LOOPNZ = 4'd15
  } br_cond_e;

  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zro;
    logic cry;
  } br_flags_t;

  function automatic logic br_is_loop(br_cond_e c);
    return (c == BR_LOOP) || (c == BR_LOOPZ) || (c == BR_LOOPNZ);
  endfunction

endpackage

// File: rtl/br_flag_eval.sv
module br_flag_eval
  import br_pkg::*;
(
  input  br_cond_e  sel,
  input  br_flags_t flg,
  output logic      hit
);

  logic sgn_ne_ovf;

  always_comb begin
    sgn_ne_ovf = flg.sgn ^ flg.ovf;
    unique case (sel)
      BR_JMP:  hit = 1'b1;
      BR_EQ:   hit = flg.zro;
      BR_NE:   hit = ~flg.zro;
      BR_SGT:  hit = ~flg.zro & ~sgn_ne_ovf;
      BR_SGE:  hit = ~sgn_ne_ovf;
      BR_SLT:  hit = sgn_ne_ovf;
      BR_SLE:  hit = sgn_ne_ovf | flg.zro;
      BR_UGT:  hit = ~flg.cry & ~flg.zro;
      BR_UGE:  hit = ~flg.cry;
      BR_ULT:  hit = flg.cry;
      BR_ULE:  hit = flg.cry | flg.zro;
      BR_OV:   hit = flg.ovf;
      BR_NOV:  hit = ~flg.ovf;
      default: hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/br_loop_unit.sv
module br_loop_unit
  import br_pkg::*;
#(
  parameter int CTR_W = 32
) (
  input  br_cond_e          sel,
  input  logic              zro,
  input  logic [CTR_W-1:0]  ctr_cur,
  output logic [CTR_W-1:0]  ctr_dec,
  output logic              hit
);

  localparam logic [CTR_W-1:0] ONE = CTR_W'(1);

  logic nonzero;

  always_comb begin
    ctr_dec = ctr_cur - ONE;
    nonzero = |ctr_dec;
    unique case (sel)
      BR_LOOP:   hit = nonzero;
      BR_LOOPZ:  hit = nonzero & zro;
      BR_LOOPNZ: hit = nonzero & ~zro;
      default:   hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/br_out_reg.sv
module br_out_reg #(
  parameter int ADDR_W = 32,
  parameter int CTR_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              d_valid,
  input  logic              d_taken,
  input  logic [ADDR_W-1:0] d_ip,
  input  logic [CTR_W-1:0]  d_ctr,
  input  logic              d_we,
  output logic              q_valid,
  output logic              q_taken,
  output logic [ADDR_W-1:0] q_ip,
  output logic [CTR_W-1:0]  q_ctr,
  output logic              q_we
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q_taken <= 1'b0;
      q_ip    <= '0;
      q_ctr   <= '0;
      q_we    <= 1'b0;
    end else begin
      q_valid <= d_valid;
      if (d_valid) begin
        q_taken <= d_taken;
        q_ip    <= d_ip;
        q_ctr   <= d_ctr;
        q_we    <= d_we;
      end
    end
  end

endmodule

// File: rtl/branch_resolver.sv
module branch_resolver
  import br_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CTR_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [3:0]        cond,
  input  logic [3:0]        flags,
  input  logic [CTR_W-1:0]  ctr_in,
  input  logic [ADDR_W-1:0] fall_ip,
  input  logic [ADDR_W-1:0] tgt_ip,
  output logic              out_valid,
  output logic              taken,
  output logic [ADDR_W-1:0] next_ip,
  output logic [CTR_W-1:0]  ctr_out,
  output logic              ctr_we
);

  br_cond_e          sel;
  br_flags_t         flg;
  logic              jmp_hit;
  logic              loop_hit;
  logic              is_loop;
  logic [CTR_W-1:0]  ctr_dec;
  logic              take_c;
  logic [ADDR_W-1:0] ip_c;
  logic [CTR_W-1:0]  ctr_c;

  assign sel = br_cond_e'(cond);
  assign flg = br_flags_t'(flags);

  br_flag_eval u_flag_eval (
    .sel (sel),
    .flg (flg),
    .hit (jmp_hit)
  );

  br_loop_unit #(.CTR_W(CTR_W)) u_loop_unit (
    .sel     (sel),
    .zro     (flg.zro),
    .ctr_cur (ctr_in),
    .ctr_dec (ctr_dec),
    .hit     (loop_hit)
  );

  always_comb begin
    is_loop = br_is_loop(sel);
    take_c  = is_loop ? loop_hit : jmp_hit;
    ip_c    = take_c ? tgt_ip : fall_ip;
    ctr_c   = is_loop ? ctr_dec : ctr_in;
  end

  br_out_reg #(.ADDR_W(ADDR_W), .CTR_W(CTR_W)) u_out_reg (
    .clk     (clk),
    .rst     (rst),
    .d_valid (in_valid),
    .d_taken (take_c),
    .d_ip    (ip_c),
    .d_ctr   (ctr_c),
    .d_we    (is_loop),
    .q_valid (out_valid),
    .q_taken (taken),
    .q_ip    (next_ip),
    .q_ctr   (ctr_out),
    .q_we    (ctr_we)
  );

endmodule

// File: rtl/br_checker.sv
module br_checker #(
  parameter int ADDR_W = 32,
  parameter int CTR_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [3:0]        cond,
  input logic [3:0]        flags,
  input logic [CTR_W-1:0]  ctr_in,
  input logic [ADDR_W-1:0] fall_ip,
  input logic [ADDR_W-1:0] tgt_ip,
  input logic              out_valid,
  input logic              taken,
  input logic [ADDR_W-1:0] next_ip,
  input logic [CTR_W-1:0]  ctr_out,
  input logic              ctr_we
);

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  p_jmp_target_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cond == 4'd0) |=> (taken && next_ip == $past(tgt_ip)));

  p_fallthrough_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cond != 4'd0) |=> (taken || next_ip == $past(fall_ip)));

  p_loop_dec_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cond == 4'd13) |=> (ctr_out == $past(ctr_in) - CTR_W'(1)));

  p_loop_we_r11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cond >= 4'd13) |=> ctr_we);

  p_jump_no_we_r11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cond < 4'd13) |=> (!ctr_we && ctr_out == $past(ctr_in)));

  p_wrap_taken_r12: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cond == 4'd13 && ctr_in == '0) |=> taken);

  p_last_pass_r10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cond >= 4'd13 && ctr_in == CTR_W'(1)) |=> !taken);

endmodule

bind branch_resolver br_checker #(.ADDR_W(ADDR_W), .CTR_W(CTR_W)) u_br_checker (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .cond      (cond),
  .flags     (flags),
  .ctr_in    (ctr_in),
  .fall_ip   (fall_ip),
  .tgt_ip    (tgt_ip),
  .out_valid (out_valid),
  .taken     (taken),
  .next_ip   (next_ip),
  .ctr_out   (ctr_out),
  .ctr_we    (ctr_we)
);

// File: tb/branch_resolver_bench.sv
`timescale 1ns/1ps
module branch_resolver_bench;

  localparam int AW = 32;
  localparam int CW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [3:0]    cond = '0;
  logic [3:0]    flags = '0;
  logic [CW-1:0] ctr_in = '0;
  logic [AW-1:0] fall_ip = '0;
  logic [AW-1:0] tgt_ip = '0;
  logic          out_valid;
  logic          taken;
  logic [AW-1:0] next_ip;
  logic [CW-1:0] ctr_out;
  logic          ctr_we;

  always #2.5 clk = ~clk;

  branch_resolver #(.ADDR_W(AW), .CTR_W(CW)) u_branch_resolver (
    .clk(clk), .rst(rst), .in_valid(in_valid), .cond(cond), .flags(flags),
    .ctr_in(ctr_in), .fall_ip(fall_ip), .tgt_ip(tgt_ip),
    .out_valid(out_valid), .taken(taken), .next_ip(next_ip),
    .ctr_out(ctr_out), .ctr_we(ctr_we)
  );

  typedef struct {
    logic          tk;
    logic [AW-1:0] ip;
    logic [CW-1:0] ctr;
    logic          we;
    string         tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Expected decision from the requirement text; flags {OF,SF,ZF,CF}
  function automatic logic want_jump(int c, logic [3:0] f);
    logic cf, zf, sf, of;
    cf = f[0]; zf = f[1]; sf = f[2]; of = f[3];
    case (c)
      0:  return 1'b1;
      1:  return zf;
      2:  return !zf;
      3:  return !zf && (sf == of);
      4:  return sf == of;
      5:  return sf != of;
      6:  return (sf != of) || zf;
      7:  return !cf && !zf;
      8:  return !cf;
      9:  return cf;
      10: return cf || zf;
      11: return of;
      12: return !of;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string req_of(int c);
    if (c == 0) return "R3";
    if (c <= 2) return "R4";
    if (c <= 6) return "R5";
    if (c <= 10) return "R6";
    if (c <= 12) return "R7";
    if (c == 13) return "R9";
    return "R10";
  endfunction

  task automatic drive(int c, logic [3:0] f, logic [CW-1:0] ctr,
                       logic [AW-1:0] fa, logic [AW-1:0] tg, string extra);
    exp_t e;
    logic [CW-1:0] dec;
    @(negedge clk);
    in_valid = 1'b1; cond = 4'(c); flags = f; ctr_in = ctr;
    fall_ip = fa; tgt_ip = tg;
    if (c >= 13) begin
      dec = ctr - 1;
      e.tk = (dec != 0) && (c == 13 || (c == 14 && f[1]) || (c == 15 && !f[1]));
      e.ctr = dec;
      e.we = 1'b1;
    end else begin
      e.tk = want_jump(c, f);
      e.ctr = ctr;
      e.we = 1'b0;
    end
    e.ip = e.tk ? tg : fa;
    e.tag = {req_of(c), extra};
    exp_q.push_back(e);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // Monitor: results are registered, sample at the falling edge
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (!rst && out_valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2", "unexpected out_valid", 1, 0);
        end else begin
          e = exp_q.pop_front();
          chk(taken == e.tk, e.tag, "taken", taken, e.tk);
          chk(next_ip == e.ip, e.tk ? e.tag : {e.tag, "/R8"}, "next_ip", next_ip, e.ip);
          chk(ctr_out == e.ctr, {e.tag, "/R11"}, "ctr_out", ctr_out, e.ctr);
          chk(ctr_we == e.we, "R11", "ctr_we", ctr_we, e.we);
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [CW-1:0] cts[6];
    cts = '{32'd0, 32'd1, 32'd2, 32'd5, 32'h8000_0000, 32'hFFFF_FFFF};
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset values
    chk(out_valid == 0, "R1", "out_valid", out_valid, 0);
    chk(taken == 0, "R1", "taken", taken, 0);
    chk(next_ip == 0, "R1", "next_ip", next_ip, 0);
    chk(ctr_out == 0 && ctr_we == 0, "R1", "ctr", ctr_out, 0);
    rst = 1'b0;

    // R3..R7, R8: every jump selector against every flag pattern
    for (int c = 0; c <= 12; c++) begin
      for (int f = 0; f < 16; f++) begin
        drive(c, 4'(f), 32'h1000 + 32'(c * 16 + f), 32'h4000_0000 + 32'(c), 32'h8000_0100 + 32'(f), "");
        if (f == 7) idle(1); // R2: a gap drops out_valid
      end
    end
    idle(2);
    chk(out_valid == 0, "R2", "idle out_valid", out_valid, 0);

    // R9, R10, R12: loop forms over boundary counters and both ZF values
    for (int c = 13; c <= 15; c++) begin
      for (int k = 0; k < 6; k++) begin
        for (int z = 0; z < 2; z++) begin
          drive(c, z ? 4'b1110 : 4'b1101, cts[k], 32'h0000_2000, 32'h0000_1F00,
                (cts[k] == 0) ? "/R12" : "");
        end
      end
    end
    idle(3);
    chk(exp_q.size() == 0, "R2", "results outstanding", exp_q.size(), 0);

    // R1: reset mid-stream clears the outputs
    drive(0, 4'h0, 32'd9, 32'h10, 32'h20, "");
    @(negedge clk);
    in_valid = 1'b0;
    void'(exp_q.pop_front());
    rst = 1'b1;
    @(negedge clk);
    chk(out_valid == 0 && taken == 0 && next_ip == 0, "R1", "after reset", {out_valid, taken}, 0);
    rst = 1'b0;
    idle(2);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule